// File: doc/BRIEF.md
# General-Purpose I/O Port Controller

This block runs a 32-pin general-purpose I/O port from a small word-addressed register bus. Each pin has an output latch, a direction bit, a pull-up-disable bit and a 2-bit function selector. Function 0 connects the pad to the plain GPIO path: the latch drives the pad and the direction bit enables the driver. Functions 1 to 3 hand the pad to one of three alternate peripheral sources. Those sources supply both the pad value and the output enable.

Software changes the latch in one of two ways. It can load the whole word through the data register. It can also update selected bits through set, clear and toggle views, so that no read-modify-write is needed. A second group of set, clear and toggle masks lets other on-chip agents update the latch in the same cycle as a bus write.

The direction, function and pull-up-disable registers are write-protected. A write to any of them lands only while the protection flag is open. The flag is opened by an unlock command pulse and shut by a lock command pulse. Pad inputs pass through a two-flop synchroniser before software can read them.

Top module: `gpio_port`

## Requirements
- R1: After reset, the latch, direction, function and pull-up-disable registers are all zero, and the protection flag is shut. All pins therefore run as GPIO inputs, with pad_oe_o at zero.
- R2: For a pin with function 0, pad_oe_o equals the pin's direction bit (1 = output, 0 = input), and pad_out_o equals the pin's latch bit.
- R3: Function fields are 2 bits per pin. The word at address 5 holds pins 0 to 15, with pin p at bits 2p+1:2p. The word at address 6 holds pins 16 to 31, with pin p at bits 2(p-16)+1:2(p-16). A field value k from 1 to 3 drives pad_out_o[p] from alt_out_i[(k-1)*32+p] and pad_oe_o[p] from alt_oe_i[(k-1)*32+p]. func_o carries all fields with pin p at bits 2p+1:2p.
- R4: Writes to direction (address 4), function (5, 6) and pull-up-disable (7) are ignored while the flag is shut. A pulse on unlock_i opens the flag from the next cycle. A pulse on lock_i shuts it, and lock wins if both pulse together. A protected write in the same cycle as unlock_i is still ignored.
- R5: A write to the data register (address 0) loads the whole latch. This write is not protected.
- R6: Writing to set (address 1), clear (address 2) or toggle (address 3) drives each latch bit written as 1 high, low or inverted, respectively. Bits written as 0 are unchanged.
- R7: Reading address 0 returns the latch bit for output pins and the synchronised pad bit for input pins. Addresses 1 to 3 read as zero. Addresses 4 to 7 read back their registers. The read data is combinational on bus_addr_i.
- R8: A change on pad_in_i first shows in the data read after the second rising clock edge that samples it.
- R9: evt_set_i, evt_clr_i and evt_tgl_i act like the bus views and merge with them in the same cycle, and also with a data load. On any bit, clear beats set, and set or clear beats toggle.
- R10: The pull-up-disable register drives pad_pud_dis_o directly, one bit per pin.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_we_i | input | 1 | Register write strobe |
| bus_addr_i | input | 3 | Word address |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for bus_addr_i |
| unlock_i | input | 1 | Opens protection flag |
| lock_i | input | 1 | Shuts protection flag |
| evt_set_i | input | 32 | Agent set mask |
| evt_clr_i | input | 32 | Agent clear mask |
| evt_tgl_i | input | 32 | Agent toggle mask |
| pad_in_i | input | 32 | Pad input values |
| alt_out_i | input | 96 | Alternate output values, source k-1 at bits (k-1)*32 up |
| alt_oe_i | input | 96 | Alternate output enables, same layout |
| pad_out_o | output | 32 | Pad output values |
| pad_oe_o | output | 32 | Pad output enables |
| pad_pud_dis_o | output | 32 | Pull-up disable per pin |
| func_o | output | 64 | Function select per pin |

## Verification
A wrong latch bit shows on pad_out_o for a GPIO pin on the cycle after the faulty write. The same bit shows in the data read whenever that pin is an output. A protection fault is visible in the register readback and in pad_oe_o or func_o one cycle after the write that should have been dropped. A synchroniser depth error moves the moment an input pin's change appears in the data read by one cycle. The bench therefore compares every address and every pad output after each cycle against its own model.

// File: rtl/gpio_port_pkg.sv
`timescale 1ns/1ps
package gpio_port_pkg;
  localparam int ADDR_W  = 3;
  localparam int FUNC_W  = 2;
  localparam int NUM_ALT = (1 << FUNC_W) - 1;

  typedef enum logic [ADDR_W-1:0] {
    REG_DATA    = 3'd0,
    REG_SET     = 3'd1,
    REG_CLR     = 3'd2,
    REG_TGL     = 3'd3,
    REG_DIR     = 3'd4,
    REG_FUNC_LO = 3'd5,
    REG_FUNC_HI = 3'd6,
    REG_PUD     = 3'd7
  } reg_sel_e;
endpackage

// File: rtl/gpio_sync.sv
`timescale 1ns/1ps
module gpio_sync #(
  parameter int W      = 32,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] st_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q[0] <= '0;
    else         st_q[0] <= d_i;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) st_q[s] <= '0;
      else         st_q[s] <= st_q[s-1];
    end
  end

  assign q_o = st_q[STAGES-1];
endmodule

// File: rtl/gpio_out_latch.sv
`timescale 1ns/1ps
module gpio_out_latch #(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         ld_i,
  input  logic [W-1:0] ld_val_i,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  input  logic [W-1:0] tgl_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] q_q, base, tgl_eff;

  // clear > set > toggle
  always_comb begin
    base    = ld_i ? ld_val_i : q_q;
    tgl_eff = tgl_i & ~set_i & ~clr_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_q <= '0;
    else         q_q <= ((base ^ tgl_eff) | set_i) & ~clr_i;
  end

  assign q_o = q_q;
endmodule

// File: rtl/gpio_ctrl_regs.sv
`timescale 1ns/1ps
module gpio_ctrl_regs
  import gpio_port_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int NPINS  = DATA_W
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    unlock_i,
  input  logic                    lock_i,
  input  logic                    we_i,
  input  logic [ADDR_W-1:0]       sel_i,
  input  logic [DATA_W-1:0]       wdata_i,
  output logic                    unlocked_o,
  output logic [NPINS-1:0]        dir_o,
  output logic [NPINS-1:0]        pud_o,
  output logic [FUNC_W*NPINS-1:0] func_o
);
  localparam int NFREG     = FUNC_W * NPINS / DATA_W;
  localparam int FUNC_BASE = int'(REG_FUNC_LO);

  logic                    unlocked_q, wr_ok;
  logic [NPINS-1:0]        dir_q, pud_q;
  logic [FUNC_W*NPINS-1:0] func_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       unlocked_q <= 1'b0;
    else if (lock_i)   unlocked_q <= 1'b0;
    else if (unlock_i) unlocked_q <= 1'b1;
  end

  assign wr_ok = we_i & unlocked_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dir_q <= '0;
      pud_q <= '0;
    end else if (wr_ok) begin
      if (sel_i == REG_DIR) dir_q <= wdata_i[NPINS-1:0];
      if (sel_i == REG_PUD) pud_q <= wdata_i[NPINS-1:0];
    end
  end

  for (genvar r = 0; r < NFREG; r++) begin : g_freg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)
        func_q[r*DATA_W +: DATA_W] <= '0;
      else if (wr_ok && sel_i == ADDR_W'(FUNC_BASE + r))
        func_q[r*DATA_W +: DATA_W] <= wdata_i;
    end
  end

  assign unlocked_o = unlocked_q;
  assign dir_o      = dir_q;
  assign pud_o      = pud_q;
  assign func_o     = func_q;
endmodule

// File: rtl/gpio_pin_mux.sv
`timescale 1ns/1ps
module gpio_pin_mux
  import gpio_port_pkg::*;
#(
  parameter int NPINS = 32
) (
  input  logic [FUNC_W*NPINS-1:0]  func_i,
  input  logic [NPINS-1:0]         gpio_out_i,
  input  logic [NPINS-1:0]         gpio_dir_i,
  input  logic [NUM_ALT*NPINS-1:0] alt_out_i,
  input  logic [NUM_ALT*NPINS-1:0] alt_oe_i,
  output logic [NPINS-1:0]         pad_out_o,
  output logic [NPINS-1:0]         pad_oe_o
);
  for (genvar p = 0; p < NPINS; p++) begin : g_pin
    logic [FUNC_W-1:0]  fsel;
    logic [NUM_ALT-1:0] a_out, a_oe;

    assign fsel = func_i[p*FUNC_W +: FUNC_W];

    for (genvar k = 0; k < NUM_ALT; k++) begin : g_alt
      assign a_out[k] = alt_out_i[k*NPINS + p];
      assign a_oe[k]  = alt_oe_i[k*NPINS + p];
    end

    always_comb begin
      if (fsel == '0) begin
        pad_out_o[p] = gpio_out_i[p];
        pad_oe_o[p]  = gpio_dir_i[p];
      end else begin
        pad_out_o[p] = a_out[fsel - 1'b1];
        pad_oe_o[p]  = a_oe[fsel - 1'b1];
      end
    end
  end
endmodule

// File: rtl/gpio_port.sv
`timescale 1ns/1ps
module gpio_port
  import gpio_port_pkg::*;
#(
  parameter int DATA_W      = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     bus_we_i,
  input  logic [ADDR_W-1:0]        bus_addr_i,
  input  logic [DATA_W-1:0]        bus_wdata_i,
  output logic [DATA_W-1:0]        bus_rdata_o,
  input  logic                     unlock_i,
  input  logic                     lock_i,
  input  logic [DATA_W-1:0]        evt_set_i,
  input  logic [DATA_W-1:0]        evt_clr_i,
  input  logic [DATA_W-1:0]        evt_tgl_i,
  input  logic [DATA_W-1:0]        pad_in_i,
  input  logic [NUM_ALT*DATA_W-1:0] alt_out_i,
  input  logic [NUM_ALT*DATA_W-1:0] alt_oe_i,
  output logic [DATA_W-1:0]        pad_out_o,
  output logic [DATA_W-1:0]        pad_oe_o,
  output logic [DATA_W-1:0]        pad_pud_dis_o,
  output logic [FUNC_W*DATA_W-1:0] func_o
);
  localparam int NPINS = DATA_W;

  logic                    unlocked_q;
  logic [NPINS-1:0]        dir_q, pud_q, out_q, sync_q;
  logic [FUNC_W*NPINS-1:0] func_q;
  logic                    wr_data;
  logic [NPINS-1:0]        set_m, clr_m, tgl_m;

  // Data views: bus and agent masks merge before priority resolution
  always_comb begin
    wr_data = bus_we_i && (bus_addr_i == REG_DATA);
    set_m   = evt_set_i | ((bus_we_i && bus_addr_i == REG_SET) ? bus_wdata_i : '0);
    clr_m   = evt_clr_i | ((bus_we_i && bus_addr_i == REG_CLR) ? bus_wdata_i : '0);
    tgl_m   = evt_tgl_i | ((bus_we_i && bus_addr_i == REG_TGL) ? bus_wdata_i : '0);
  end

  gpio_out_latch #(.W(NPINS)) u_latch (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .ld_i     (wr_data),
    .ld_val_i (bus_wdata_i),
    .set_i    (set_m),
    .clr_i    (clr_m),
    .tgl_i    (tgl_m),
    .q_o      (out_q)
  );

  gpio_ctrl_regs #(.DATA_W(DATA_W), .NPINS(NPINS)) u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .unlock_i   (unlock_i),
    .lock_i     (lock_i),
    .we_i       (bus_we_i),
    .sel_i      (bus_addr_i),
    .wdata_i    (bus_wdata_i),
    .unlocked_o (unlocked_q),
    .dir_o      (dir_q),
    .pud_o      (pud_q),
    .func_o     (func_q)
  );

  gpio_sync #(.W(NPINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (pad_in_i),
    .q_o    (sync_q)
  );

  gpio_pin_mux #(.NPINS(NPINS)) u_mux (
    .func_i     (func_q),
    .gpio_out_i (out_q),
    .gpio_dir_i (dir_q),
    .alt_out_i  (alt_out_i),
    .alt_oe_i   (alt_oe_i),
    .pad_out_o  (pad_out_o),
    .pad_oe_o   (pad_oe_o)
  );

  always_comb begin
    unique case (bus_addr_i)
      REG_DATA:    bus_rdata_o = (out_q & dir_q) | (sync_q & ~dir_q);
      REG_DIR:     bus_rdata_o = dir_q;
      REG_FUNC_LO: bus_rdata_o = func_q[0 +: DATA_W];
      REG_FUNC_HI: bus_rdata_o = func_q[DATA_W +: DATA_W];
      REG_PUD:     bus_rdata_o = pud_q;
      default:     bus_rdata_o = '0;
    endcase
  end

  assign pad_pud_dis_o = pud_q;
  assign func_o        = func_q;
endmodule

// File: rtl/gpio_port_chk.sv
`timescale 1ns/1ps
module gpio_port_chk
  import gpio_port_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input logic                     clk_i,
  input logic                     rst_ni,
  input logic                     bus_we_i,
  input logic [ADDR_W-1:0]        bus_addr_i,
  input logic [DATA_W-1:0]        bus_wdata_i,
  input logic                     unlock_i,
  input logic                     lock_i,
  input logic [DATA_W-1:0]        evt_set_i,
  input logic [DATA_W-1:0]        evt_clr_i,
  input logic [DATA_W-1:0]        evt_tgl_i,
  input logic [DATA_W-1:0]        pad_in_i,
  input logic                     unlocked_q,
  input logic [DATA_W-1:0]        dir_q,
  input logic [DATA_W-1:0]        pud_q,
  input logic [FUNC_W*DATA_W-1:0] func_q,
  input logic [DATA_W-1:0]        out_q,
  input logic [DATA_W-1:0]        sync_q,
  input logic [DATA_W-1:0]        pad_out_o,
  input logic [DATA_W-1:0]        pad_oe_o
);
  logic [1:0]        cyc_q;
  logic [DATA_W-1:0] gpio_mask;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          cyc_q <= '0;
    else if (cyc_q != 2'd2) cyc_q <= cyc_q + 2'd1;
  end

  always_comb begin
    for (int p = 0; p < DATA_W; p++)
      gpio_mask[p] = (func_q[p*FUNC_W +: FUNC_W] == '0);
  end

  p_locked_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !unlocked_q |=> ($stable(dir_q) && $stable(pud_q) && $stable(func_q)));

  p_lock_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lock_i |=> !unlocked_q);

  p_unlock_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (unlock_i && !lock_i) |=> unlocked_q);

  p_set_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_we_i && bus_addr_i == REG_SET && evt_clr_i == '0)
      |=> ((out_q & $past(bus_wdata_i)) == $past(bus_wdata_i)));

  p_tgl_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!bus_we_i && evt_set_i == '0 && evt_clr_i == '0)
      |=> (out_q == ($past(out_q) ^ $past(evt_tgl_i))));

  p_clr_wins_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_clr_i != '0) |=> ((out_q & $past(evt_clr_i)) == '0));

  p_gpio_path_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (((pad_oe_o ^ dir_q) & gpio_mask) == '0) && (((pad_out_o ^ out_q) & gpio_mask) == '0));

  p_sync_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc_q == 2'd2) |-> (sync_q == $past(pad_in_i, 2)));

  p_pud_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (unlocked_q && bus_we_i && bus_addr_i == REG_PUD) |=> (pud_q == $past(bus_wdata_i)));
endmodule

bind gpio_port gpio_port_chk #(.DATA_W(DATA_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .bus_we_i    (bus_we_i),
  .bus_addr_i  (bus_addr_i),
  .bus_wdata_i (bus_wdata_i),
  .unlock_i    (unlock_i),
  .lock_i      (lock_i),
  .evt_set_i   (evt_set_i),
  .evt_clr_i   (evt_clr_i),
  .evt_tgl_i   (evt_tgl_i),
  .pad_in_i    (pad_in_i),
  .unlocked_q  (unlocked_q),
  .dir_q       (dir_q),
  .pud_q       (pud_q),
  .func_q      (func_q),
  .out_q       (out_q),
  .sync_q      (sync_q),
  .pad_out_o   (pad_out_o),
  .pad_oe_o    (pad_oe_o)
);

// File: tb/gpio_port_tb.sv
`timescale 1ns/1ps
module gpio_port_tb;
  import gpio_port_pkg::*;
  localparam int W = 32;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  always #2.5 clk_i = ~clk_i;

  logic                 bus_we_i = 1'b0;
  logic [ADDR_W-1:0]    bus_addr_i = '0;
  logic [W-1:0]         bus_wdata_i = '0;
  logic [W-1:0]         bus_rdata_o;
  logic                 unlock_i = 1'b0, lock_i = 1'b0;
  logic [W-1:0]         evt_set_i = '0, evt_clr_i = '0, evt_tgl_i = '0;
  logic [W-1:0]         pad_in_i = '0;
  logic [NUM_ALT*W-1:0] alt_out_i = '0, alt_oe_i = '0;
  logic [W-1:0]         pad_out_o, pad_oe_o, pad_pud_dis_o;
  logic [FUNC_W*W-1:0]  func_o;

  gpio_port u_dut (
    .clk_i, .rst_ni, .bus_we_i, .bus_addr_i, .bus_wdata_i, .bus_rdata_o,
    .unlock_i, .lock_i, .evt_set_i, .evt_clr_i, .evt_tgl_i, .pad_in_i,
    .alt_out_i, .alt_oe_i, .pad_out_o, .pad_oe_o, .pad_pud_dis_o, .func_o
  );

  int checks = 0, fails = 0;
  bit done = 1'b0;

  // reference model
  logic [W-1:0]        m_out = '0, m_dir = '0, m_pud = '0, m_s1 = '0, m_s2 = '0;
  logic [FUNC_W*W-1:0] m_func = '0;
  logic                m_unl = 1'b0;

  function automatic logic [W-1:0] exp_rdata(input int a);
    case (a)
      0: return (m_out & m_dir) | (m_s2 & ~m_dir);
      4: return m_dir;
      5: return m_func[0 +: W];
      6: return m_func[W +: W];
      7: return m_pud;
      default: return '0;
    endcase
  endfunction

  function automatic logic [W-1:0] exp_pad(input bit want_oe);
    logic [W-1:0] r;
    for (int p = 0; p < W; p++) begin
      int f;
      f = int'(m_func[p*2 +: 2]);
      if (f == 0) r[p] = want_oe ? m_dir[p] : m_out[p];
      else        r[p] = want_oe ? alt_oe_i[(f-1)*W+p] : alt_out_i[(f-1)*W+p];
    end
    return r;
  endfunction

  task automatic model_edge();
    logic [W-1:0] s, c, t, base;
    int a;
    a = int'(bus_addr_i);
    if (bus_we_i && m_unl) begin
      if (a == 4) m_dir = bus_wdata_i;
      if (a == 5) m_func[0 +: W] = bus_wdata_i;
      if (a == 6) m_func[W +: W] = bus_wdata_i;
      if (a == 7) m_pud = bus_wdata_i;
    end
    base = (bus_we_i && a == 0) ? bus_wdata_i : m_out;
    s = evt_set_i | ((bus_we_i && a == 1) ? bus_wdata_i : '0);
    c = evt_clr_i | ((bus_we_i && a == 2) ? bus_wdata_i : '0);
    t = evt_tgl_i | ((bus_we_i && a == 3) ? bus_wdata_i : '0);
    m_out = ((base ^ (t & ~s & ~c)) | s) & ~c;
    m_s2 = m_s1;
    m_s1 = pad_in_i;
    if (lock_i) m_unl = 1'b0;
    else if (unlock_i) m_unl = 1'b1;
  endtask

  task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk_i);
    model_edge();
    @(negedge clk_i);
    bus_we_i = 1'b0; unlock_i = 1'b0; lock_i = 1'b0;
    evt_set_i = '0; evt_clr_i = '0; evt_tgl_i = '0;
  endtask

  task automatic check_all(input string tag);
    for (int a = 0; a < 8; a++) begin
      bus_addr_i = ADDR_W'(a);
      #0.1;
      chk($sformatf("%s R7 rd[%0d]", tag, a), bus_rdata_o, exp_rdata(a));
    end
    chk({tag, " R2/R3 pad_out"}, pad_out_o, exp_pad(1'b0));
    chk({tag, " R2/R3 pad_oe"}, pad_oe_o, exp_pad(1'b1));
    chk({tag, " R10 pud"}, pad_pud_dis_o, m_pud);
    chk({tag, " R3 func_lo"}, func_o[0 +: W], m_func[0 +: W]);
    chk({tag, " R3 func_hi"}, func_o[W +: W], m_func[W +: W]);
  endtask

  task automatic wr(input int a, input logic [W-1:0] d);
    bus_we_i = 1'b1; bus_addr_i = ADDR_W'(a); bus_wdata_i = d;
    tick();
  endtask

  task automatic rd(input int a, output logic [W-1:0] d);
    bus_addr_i = ADDR_W'(a);
    #0.1;
    d = bus_rdata_o;
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired act=running exp=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] v;
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk_i);
    @(negedge clk_i);
    rst_ni = 1'b1;
    // R1 reset state
    check_all("R1 reset");
    chk("R1 pad_oe zero", pad_oe_o, '0);

    // R4 locked write dropped
    wr(4, 32'hFFFF_FFFF);
    rd(4, v); chk("R4 locked dir write", v, '0);
    // R4 unlock in same cycle as write: still dropped
    unlock_i = 1'b1;
    wr(4, 32'hFFFF_FFFF);
    rd(4, v); chk("R4 write with unlock", v, '0);
    check_all("R4");

    // R2 direction
    wr(4, 32'h0000_00FF);
    chk("R2 pad_oe", pad_oe_o, 32'h0000_00FF);

    // R5 data load, R7 data read mixes latch and sync
    wr(0, 32'hA5A5_A5A5);
    chk("R5 pad_out", pad_out_o, 32'hA5A5_A5A5);
    rd(0, v); chk("R7 data read mix", v, 32'h0000_00A5);

    // R6 set / clear / toggle
    wr(1, 32'h0000_00F0);
    chk("R6 set", pad_out_o, 32'hA5A5_A5F5);
    rd(1, v); chk("R7 set reads zero", v, '0);
    wr(2, 32'h0000_0021);
    chk("R6 clear", pad_out_o, 32'hA5A5_A5D4);
    wr(3, 32'h0000_00FF);
    chk("R6 toggle", pad_out_o, 32'hA5A5_A52B);
    check_all("R6");

    // R9 priority: bit0 clr+set -> 0, bit1 set+tgl -> 1, bit2 tgl -> 1
    evt_set_i = 32'h3; evt_clr_i = 32'h1; evt_tgl_i = 32'h6;
    tick();
    chk("R9 priority", pad_out_o & 32'hFF, 32'h0000_002E);
    // R9 bus clear vs agent set on bit5
    evt_set_i = 32'h20;
    wr(2, 32'h20);
    chk("R9 bus clr beats evt set", pad_out_o & 32'hFF, 32'h0000_000E);
    check_all("R9");

    // R3 function select
    alt_out_i = '0; alt_oe_i = '0;
    alt_out_i[0*W + 1] = 1'b1; alt_oe_i[0*W + 1] = 1'b1;
    alt_out_i[2*W + 20] = 1'b1; alt_oe_i[2*W + 20] = 1'b1;
    wr(5, 32'h0000_0004);
    wr(6, 32'h0000_0300);
    chk("R3 pin1 alt1 out", W'(pad_out_o[1]), W'(1));
    chk("R3 pin20 alt3 oe", W'(pad_oe_o[20]), W'(1));
    chk("R3 func_o pin20", W'(func_o[41:40]), W'(3));
    check_all("R3");

    // R10 pull-up disable
    wr(7, 32'hDEAD_BEEF);
    chk("R10 pud out", pad_pud_dis_o, 32'hDEAD_BEEF);

    // R8 two-edge sync latency on input pin 31
    pad_in_i = 32'h8000_0000;
    tick();
    rd(0, v); chk("R8 after one edge", v & 32'h8000_0000, '0);
    tick();
    rd(0, v); chk("R8 after two edges", v & 32'h8000_0000, 32'h8000_0000);

    // R4 lock wins over unlock, then writes dropped
    lock_i = 1'b1; unlock_i = 1'b1;
    tick();
    wr(4, 32'h0);
    rd(4, v); chk("R4 lock wins", v, 32'h0000_00FF);
    check_all("R4 relock");

    // random mix
    for (int i = 0; i < 400; i++) begin
      bus_we_i    = ($urandom_range(0, 9) < 7);
      bus_addr_i  = ADDR_W'($urandom_range(0, 7));
      bus_wdata_i = $urandom();
      unlock_i    = ($urandom_range(0, 7) == 0);
      lock_i      = ($urandom_range(0, 7) == 0);
      if ($urandom_range(0, 3) == 0) begin
        evt_set_i = $urandom() & $urandom();
        evt_clr_i = $urandom() & $urandom();
        evt_tgl_i = $urandom() & $urandom();
      end
      pad_in_i  = $urandom();
      alt_out_i = {$urandom(), $urandom(), $urandom()};
      alt_oe_i  = {$urandom(), $urandom(), $urandom()};
      tick();
      check_all("rand R5 R6 R9");
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule